// File: doc/BRIEF.md
# Sequential Radix-2 Decimation-in-Frequency FFT Engine

This block computes an in-place fast Fourier transform of 8, 16, 32 or 64 complex points. It uses a single shared radix-2 decimation-in-frequency butterfly. A host fills the internal sample store through a write port with a valid/ready handshake, then pulses `start` with a length code. The engine walks every stage and every butterfly and writes each result pair back to the addresses it read.

The complex twiddle product is spread over two cycles so that only two real multipliers are needed. Twiddle constants come from a small constant table. Every butterfly output is halved, so the finished spectrum is the transform scaled by 1/N. The spectrum is left in bit-reversed address order. A one-cycle `done` pulse marks the end of the run, after which the host reads any location through a combinational read port and reorders the bins itself.

Top module: `fft_r2_seq`

## Requirements
- R1: While idle, `ld_ready` is 1. Each cycle with `ld_valid` high stores (`ld_re`,`ld_im`) at `ld_addr` on the clock edge, and `rd_re`/`rd_im` show the stored value at `rd_addr` combinationally.
- R2: A `start` seen while idle latches `len_code` (0→8, 1→16, 2→32, 3→64 points, so m = 3..6) and raises `busy` from the next cycle. The transform uses only addresses 0..N−1.
- R3: `done` is high for exactly one cycle. It rises on the clock edge m·N cycles after the edge that accepted `start` (two cycles per butterfly, N/2 butterflies per stage), and `busy` falls on that same edge.
- R4: A `start` or a change of `len_code` while busy has no effect: the run is not restarted and its latency stays m·N.
- R5: While busy, `ld_ready` is 0 and `ld_valid` writes nothing to the store.
- R6: Stage s pairs index i with i+h, where h = N/2^(s+1). The upper output is (a+b)>>>1 per component. The lower output is ((a−b)·W)>>>15, with real part Re·Wr−Im·Wi formed in the first cycle and imaginary part Re·Wi+Im·Wr in the second. W = round(16384·cos θ) − j·round(16384·sin θ), θ = 2πk/64 and k = (i mod h)·2^s·64/N. Every stored result matches a fixed-point model of this arithmetic within ±2 LSB.
- R7: After a run, address bitrev_m(k) holds bin k of the forward transform (kernel e^(−j2πkn/N)) scaled by 1/N.
- R8: A transform of N < 64 points leaves locations N..63 unchanged.
- R9: During and right after reset, `busy` and `done` are 0 and `ld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform (ignored while busy) |
| len_code | input | 2 | Transform length code, sampled with start |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle end-of-transform pulse |
| ld_valid | input | 1 | Sample write request |
| ld_ready | output | 1 | Store accepts writes (idle) |
| ld_addr | input | 6 | Sample write address |
| ld_re | input | DW | Real part of sample written |
| ld_im | input | DW | Imaginary part of sample written |
| rd_addr | input | 6 | Readout address |
| rd_re | output | DW | Real part stored at rd_addr |
| rd_im | output | DW | Imaginary part stored at rd_addr |

## Verification
The properties assume that `len_code` is stable in the cycle `start` is raised and that the host never pulses `start` in the same cycle it expects the engine to be idle, except by intent. The datapath assumes input magnitudes small enough that no difference times a twiddle overflows the data width. The stimulus keeps every sample component within ±9,900, which bounds each butterfly difference well inside 16 bits after the halving. Starts and writes issued during a run are deliberate probes, driven away from clock edges.

// File: rtl/fft_r2_seq.sv
module fft_r2_seq #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           len_code,
  output logic                 busy,
  output logic                 done,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [5:0]           ld_addr,
  input  logic signed [DW-1:0] ld_re,
  input  logic signed [DW-1:0] ld_im,
  input  logic [5:0]           rd_addr,
  output logic signed [DW-1:0] rd_re,
  output logic signed [DW-1:0] rd_im
);
  localparam int AW = 6;
  localparam int NMAX = 1 << AW;
  localparam int SH = TW - 1;
  localparam int PW = DW + TW + 1;

  logic signed [DW-1:0] mre [NMAX];
  logic signed [DW-1:0] mim [NMAX];

  logic          busy_q, done_q, ph;
  logic [1:0]    code_q;
  logic [2:0]    stg, lgn, sh;
  logic [AW-2:0] bf;
  logic [AW-1:0] bfx, mask, nhalf, ia, ib;
  logic [5:0]    k;

  assign lgn   = {1'b0, code_q} + 3'd3;
  assign sh    = lgn - 3'd1 - stg;
  assign bfx   = {1'b0, bf};
  assign mask  = (AW'(1) << sh) - AW'(1);
  assign nhalf = AW'(1) << (lgn - 3'd1);
  assign ia    = ((bfx >> sh) << (sh + 3'd1)) | (bfx & mask);
  assign ib    = ia | (AW'(1) << sh);
  assign k     = 6'((bfx & mask) << (stg + 3'd6 - lgn));

  function automatic logic signed [TW-1:0] cq(input logic [5:0] x);
    case (x)
      6'd0:  cq = 16384;  6'd1:  cq = 16305;  6'd2:  cq = 16069;
      6'd3:  cq = 15679;  6'd4:  cq = 15137;  6'd5:  cq = 14449;
      6'd6:  cq = 13623;  6'd7:  cq = 12665;  6'd8:  cq = 11585;
      6'd9:  cq = 10394;  6'd10: cq = 9102;   6'd11: cq = 7723;
      6'd12: cq = 6270;   6'd13: cq = 4756;   6'd14: cq = 3196;
      6'd15: cq = 1606;   default: cq = 0;
    endcase
  endfunction

  logic signed [TW-1:0] wr, wi;
  assign wr = (k <= 6'd16) ? cq(k) : -cq(6'd32 - k);
  assign wi = (k <= 6'd16) ? -cq(6'd16 - k) : -cq(k - 6'd16);

  logic signed [DW-1:0] a_re, a_im, b_re, b_im;
  assign a_re = mre[ia];
  assign a_im = mim[ia];
  assign b_re = mre[ib];
  assign b_im = mim[ib];

  logic signed [DW:0] sr, si, dr, di, dr_q, di_q, xa, xb;
  assign sr = {a_re[DW-1], a_re} + {b_re[DW-1], b_re};
  assign si = {a_im[DW-1], a_im} + {b_im[DW-1], b_im};
  assign dr = {a_re[DW-1], a_re} - {b_re[DW-1], b_re};
  assign di = {a_im[DW-1], a_im} - {b_im[DW-1], b_im};

  assign xa = ph ? dr_q : dr;
  assign xb = ph ? di_q : di;

  logic signed [PW-1:0] m0, m1;
  logic signed [PW:0]   acc;
  logic signed [DW-1:0] res, re_q;
  assign m0  = PW'(xa) * PW'(ph ? wi : wr);
  assign m1  = PW'(xb) * PW'(ph ? wr : wi);
  assign acc = ph ? ((PW+1)'(m0) + (PW+1)'(m1)) : ((PW+1)'(m0) - (PW+1)'(m1));
  assign res = DW'(acc >>> SH);

  logic                 we;
  logic [AW-1:0]        waddr;
  logic signed [DW-1:0] wre, wim;
  assign we    = busy_q | ld_valid;
  assign waddr = busy_q ? (ph ? ib : ia) : ld_addr;
  assign wre   = busy_q ? (ph ? re_q : DW'(sr >>> 1)) : ld_re;
  assign wim   = busy_q ? (ph ? res : DW'(si >>> 1)) : ld_im;

  always_ff @(posedge clk)
    if (we) begin
      mre[waddr] <= wre;
      mim[waddr] <= wim;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph     <= 1'b0;
      code_q <= '0;
      stg    <= '0;
      bf     <= '0;
      dr_q   <= '0;
      di_q   <= '0;
      re_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          code_q <= len_code;
          stg    <= '0;
          bf     <= '0;
          ph     <= 1'b0;
        end
      end else begin
        ph <= ~ph;
        if (!ph) begin
          dr_q <= dr;
          di_q <= di;
          re_q <= res;
        end else if (bfx == nhalf - AW'(1)) begin
          bf <= '0;
          if (stg == lgn - 3'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            stg <= stg + 3'd1;
          end
        end else begin
          bf <= bf + 1'b1;
        end
      end
    end

  assign busy     = busy_q;
  assign done     = done_q;
  assign ld_ready = ~busy_q;
  assign rd_re    = mre[rd_addr];
  assign rd_im    = mim[rd_addr];
endmodule

// File: rtl/fft_r2_seq_chk.sv
module fft_r2_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] len_code,
  input logic       busy,
  input logic       done
);
  logic [11:0] cnt, lim;
  logic [1:0]  lq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      lq  <= '0;
    end else if (start && !busy) begin
      cnt <= '0;
      lq  <= len_code;
    end else if (busy) begin
      cnt <= cnt + 12'd1;
    end

  always_comb
    case (lq)
      2'd0:    lim = 12'd24;
      2'd1:    lim = 12'd64;
      2'd2:    lim = 12'd160;
      default: lim = 12'd384;
    endcase

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3 and R4: a start during a run must not shift the end of the run
  a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == lim));

  a_r3_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind fft_r2_seq fft_r2_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .len_code(len_code),
  .busy(busy), .done(done)
);

// File: tb/sim_fft_r2_seq.sv
module sim_fft_r2_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, busy, done, ld_valid, ld_ready;
  logic [1:0] len_code;
  logic [5:0] ld_addr, rd_addr;
  logic signed [15:0] ld_re, ld_im, rd_re, rd_im;

  fft_r2_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len_code(len_code),
    .busy(busy), .done(done), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_re(ld_re), .ld_im(ld_im),
    .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
  );

  int n_chk = 0, n_fail = 0;
  int xr[64], xi[64], mr[64], mi[64];
  bit finished = 0;
  localparam real PI = 3.14159265358979;

  // kind 0 impulse at position p, 1 constant, 2 tone at bin p
  localparam int VEC [8][4] = '{
    '{0, 0, 8000, 0}, '{0, 1, 4000, 0}, '{1, 2, 8000, 3},  '{2, 0, -6000, 5},
    '{3, 2, 7000, 10}, '{3, 1, -3000, 0}, '{2, 2, 8000, 31}, '{1, 0, 8000, 15}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int bitrev(input int v, input int m);
    int r = 0;
    for (int b = 0; b < m; b++) r |= ((v >> b) & 1) << (m - 1 - b);
    return r;
  endfunction

  task automatic model(input int n);
    int m = 0;
    while ((1 << m) < n) m++;
    for (int a = 0; a < 64; a++) begin mr[a] = xr[a]; mi[a] = xi[a]; end
    for (int s = 0; s < m; s++) begin
      int h = n >> (s + 1);
      for (int g = 0; g < n; g += 2 * h)
        for (int p = 0; p < h; p++) begin
          int i = g + p, j = g + p + h;
          int kk = p * (1 << s) * (64 / n);
          int wr = int'(16384.0 * $cos(2.0 * PI * kk / 64.0));
          int wi = -int'(16384.0 * $sin(2.0 * PI * kk / 64.0));
          int dr = mr[i] - mr[j], di = mi[i] - mi[j];
          mr[i] = (mr[i] + mr[j]) >>> 1;
          mi[i] = (mi[i] + mi[j]) >>> 1;
          mr[j] = (dr * wr - di * wi) >>> 15;
          mi[j] = (dr * wi + di * wr) >>> 15;
        end
    end
  endtask

  task automatic load(input int n);
    for (int a = 0; a < n; a++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 6'(a); ld_re = 16'(xr[a]); ld_im = 16'(xi[a]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run(input int code, input bit poke);
    int cyc = 0;
    int n = 8 << code;
    int m = 3 + code;
    @(negedge clk);
    start = 1'b1; len_code = 2'(code);
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
      if (poke && cyc == 5) begin
        chk(ld_ready === 1'b0, "R5 ld_ready while busy", int'(ld_ready), 0);
        start = 1'b1; len_code = 2'd3;
        ld_valid = 1'b1; ld_addr = 6'd3; ld_re = 16'sd1234; ld_im = -16'sd777;
      end
      if (poke && cyc == 6) begin
        start = 1'b0; ld_valid = 1'b0;
      end
    end
    chk(cyc == m * n, poke ? "R4 latency with start while busy" : "R3 done latency", cyc, m * n);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R3 done one cycle", int'(done), 0);
  endtask

  task automatic compare(input int n, input string req);
    int bad = 0, fa = 0, fe = 0;
    for (int r = 0; r < n; r++) begin
      rd_addr = 6'(r);
      #1;
      if (iabs(int'(rd_re) - mr[r]) > 2 || iabs(int'(rd_im) - mi[r]) > 2) begin
        if (bad == 0) begin fa = int'(rd_re); fe = mr[r]; end
        bad++;
      end
    end
    chk(bad == 0, req, fa, fe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; len_code = 2'd0; ld_valid = 1'b0;
    ld_addr = '0; ld_re = '0; ld_im = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && ld_ready === 1'b1, "R9 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && ld_ready === 1'b1, "R9 idle after reset", int'(ld_ready), 1);

    for (int v = 0; v < 8; v++) begin
      int code = VEC[v][0], kind = VEC[v][1], amp = VEC[v][2], p = VEC[v][3];
      int n = 8 << code, m = 3 + code;
      int bin, er;
      for (int a = 0; a < 64; a++) begin xr[a] = 0; xi[a] = 0; end
      for (int a = 0; a < n; a++) begin
        if (kind == 0) begin xr[a] = (a == p) ? amp : 0; end
        else if (kind == 1) begin xr[a] = amp; end
        else begin
          xr[a] = int'(amp * $cos(2.0 * PI * p * a / n));
          xi[a] = int'(amp * $sin(2.0 * PI * p * a / n));
        end
      end
      load(n);
      run(code, 1'b0);
      model(n);
      compare(n, "R6 butterfly arithmetic vs model");
      bin = (kind == 2) ? p : 0;
      er  = (kind == 0) ? amp / n : amp;
      rd_addr = 6'(bitrev(bin, m));
      #1;
      chk(iabs(int'(rd_re) - er) <= 8, "R7 bin at bit-reversed address", int'(rd_re), er);
    end

    for (int a = 0; a < 64; a++) begin xr[a] = a * 300 - 9000; xi[a] = 5000 - a * 120; end
    load(64);
    rd_addr = 6'd50;
    #1;
    chk(int'(rd_re) == xr[50] && int'(rd_im) == xi[50], "R1 load readback", int'(rd_re), xr[50]);
    run(0, 1'b1);
    model(8);
    compare(8, "R5 write while busy ignored");
    begin
      int bad = 0, fa = 0, fe = 0;
      for (int r = 8; r < 64; r++) begin
        rd_addr = 6'(r);
        #1;
        if (int'(rd_re) != xr[r] || int'(rd_im) != xi[r]) begin
          if (bad == 0) begin fa = int'(rd_re); fe = xr[r]; end
          bad++;
        end
      end
      chk(bad == 0, "R8 upper locations untouched", fa, fe);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule